// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the CPU-facing register set of an SMBus host controller. Software programs a target address, a command code and a byte count through byte-wide register accesses. It fills or drains a block buffer through a single auto-incrementing data port. It then sets a start bit to run a block write or a block read on the bus.

The block does not toggle clock or data lines itself. It sequences a byte-level bus master through a request/response port. Each request carries one operation: start condition, write byte, read byte or stop condition. The master answers each request with a one-cycle done pulse, which returns the received byte and, for writes, whether the device acknowledged.

Software learns the outcome from sticky status flags that it clears by writing ones. The outcomes are completion, device error and failure after a kill.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, status (offset 0x0), control (0x2), data 0 (0x5) and auxiliary control (0xD) read as zero, and no bus request is pending.
- R2: Command (0x3), transmit address (0x4), data 0, data 1 (0x6) and auxiliary control read back what was written. Auxiliary control keeps only bits 1:0.
- R3: The data port (0x7) reads or writes buffer entry `index` and then advances `index` by one, wrapping at DEPTH. A read of the control register sets `index` to zero.
- R4: A control write with bit 6 set and bits 4:2 equal to 5 launches a transfer, but only when no transfer is running. Any other protocol value does not launch. The control register reads its stored bits 0, 4:2, 5 and 7, and always reads 0 in bits 6 (start) and 1 (kill).
- R5: A block write (transmit address bit 0 = 0) issues this exact sequence: start, write of `{addr[7:1],0}`, write of the command byte, write of the count from data 0, then count bytes taken from buffer entries 0 upward, then stop. Each request stays stable until its done pulse.
- R6: A block read (transmit address bit 0 = 1) issues this sequence: start, write of `{addr[7:1],0}`, write of the command byte, repeated start, write of `{addr[7:1],1}`, read of the count byte, then count byte reads, then stop. The last-byte flag is set only on the final data read. The count is stored in data 0, and the data bytes are stored in buffer entries 0 upward.
- R7: Status bit 0 (busy) is 1 from the cycle after launch until the stop completes. A transfer that succeeds then sets status bit 1 (complete).
- R8: Writing status clears each of bits 1, 2 and 4 where the written byte has a one, and leaves the other flags unchanged.
- R9: A write byte answered with a not-acknowledge is followed directly by a stop. The transfer then sets status bit 2 (device error) and does not set complete.
- R10: A block read whose count byte is 0 or greater than DEPTH is followed directly by a stop and sets device error. Data 0 still holds the received count.
- R11: A control write with bit 1 (kill) set during a transfer ends the transfer. Once the current request is answered, a stop is issued, status bit 4 (failed) is set, and busy clears without complete being set.
- R12: With auxiliary control bit 1 cleared, data port accesses do not advance the index.
- R13: A start written while busy is ignored: no extra bus sequence follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | CPU register offset |
| bus_wr | input | 1 | CPU write strobe, one cycle per access |
| bus_rd | input | 1 | CPU read strobe, one cycle per access (drives read side effects) |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data for `bus_addr`, combinational |
| m_valid | output | 1 | Byte-master request pending |
| m_op | output | 2 | Request operation: 0 start, 1 write byte, 2 read byte, 3 stop |
| m_wdata | output | 8 | Byte to send for a write request (0 otherwise) |
| m_last | output | 1 | Final data byte of a block read |
| m_done | input | 1 | One-cycle response ending the current request |
| m_nack | input | 1 | With `m_done`: the written byte was not acknowledged |
| m_rdata | input | 8 | With `m_done`: byte received by a read request |

## Verification
The bench builds the block with DEPTH = 8. With that depth a count byte of 9 exceeds the buffer, so the overflow abort can be reached in a few cycles. Buffer wrap also stays within a short run. The byte master model answers each request two cycles after it is raised. That gap leaves room for a kill, and for a second start, to land while a request is still outstanding.

// File: rtl/smbus_host_regs.sv
module smbus_host_regs #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       m_valid,
  output logic [1:0] m_op,
  output logic [7:0] m_wdata,
  output logic       m_last,
  input  logic       m_done,
  input  logic       m_nack,
  input  logic [7:0] m_rdata
);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [8:0] DMAX = 9'(DEPTH);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] RES_OK = 2'd0, RES_DEV = 2'd1, RES_KILL = 2'd2;

  typedef enum logic [3:0] {IDLE, ST, AD, CM, RS, RA, CT, DT, SP} st_t;

  st_t            st;
  logic [7:0]     cmd_r, addr_r, d0, d1, cnt, xi;
  logic [1:0]     aux, res;
  logic [2:0]     proto;
  logic           ie, lastb, pec, f_done, f_dev, f_fail, rd_x, kill_p;
  logic [IDXW-1:0] cidx;
  logic [7:0]     mem [DEPTH];

  wire busy   = st != IDLE;
  wire adv    = busy && m_done;
  wire launch = bus_wr && bus_addr == 4'h2 && bus_wdata[6] && bus_wdata[4:2] == 3'd5 && !busy;
  wire final_byte = xi == cnt - 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cmd_r <= '0; addr_r <= '0; d0 <= '0; d1 <= '0; cnt <= '0; xi <= '0;
      aux <= '0; res <= RES_OK; proto <= '0; ie <= 1'b0; lastb <= 1'b0; pec <= 1'b0;
      f_done <= 1'b0; f_dev <= 1'b0; f_fail <= 1'b0; rd_x <= 1'b0; kill_p <= 1'b0; cidx <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          4'h0: {f_fail, f_dev, f_done} <= {f_fail, f_dev, f_done} & ~{bus_wdata[4], bus_wdata[2], bus_wdata[1]};
          4'h2: begin
            {pec, lastb, proto, ie} <= {bus_wdata[7], bus_wdata[5], bus_wdata[4:2], bus_wdata[0]};
            if (bus_wdata[1] && busy) kill_p <= 1'b1;
          end
          4'h3: cmd_r <= bus_wdata;
          4'h4: addr_r <= bus_wdata;
          4'h5: d0 <= bus_wdata;
          4'h6: d1 <= bus_wdata;
          4'h7: if (!busy && aux[1]) cidx <= cidx + 1'b1;
          4'hD: aux <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (bus_rd && bus_addr == 4'h2) cidx <= '0;
      else if (bus_rd && bus_addr == 4'h7 && aux[1]) cidx <= cidx + 1'b1;

      if (launch) begin
        st <= ST; rd_x <= addr_r[0]; kill_p <= 1'b0; res <= RES_OK;
      end else if (adv) begin
        if (st == SP) begin
          st <= IDLE;
          case (res)
            RES_OK:  f_done <= 1'b1;
            RES_DEV: f_dev  <= 1'b1;
            default: f_fail <= 1'b1;
          endcase
        end else if (kill_p) begin
          st <= SP; res <= RES_KILL;
        end else if (m_op == OP_WR && m_nack) begin
          st <= SP; res <= RES_DEV;
        end else begin
          case (st)
            ST: st <= AD;
            AD: st <= CM;
            CM: st <= rd_x ? RS : CT;
            RS: st <= RA;
            RA: st <= CT;
            CT: begin
              xi <= '0;
              if (rd_x) begin
                d0 <= m_rdata; cnt <= m_rdata;
                if (m_rdata == 8'd0 || {1'b0, m_rdata} > DMAX) begin st <= SP; res <= RES_DEV; end
                else st <= DT;
              end else begin
                cnt <= d0;
                st <= (d0 == 8'd0) ? SP : DT;
              end
            end
            DT: begin
              xi <= xi + 8'd1;
              if (final_byte) st <= SP;
            end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv && st == DT && rd_x) mem[xi[IDXW-1:0]] <= m_rdata;
    else if (bus_wr && bus_addr == 4'h7 && !busy) mem[cidx] <= bus_wdata;
  end

  assign m_valid = busy;
  assign m_last  = st == DT && rd_x && final_byte;

  always_comb begin
    case (st)
      ST, RS:  m_op = OP_START;
      SP:      m_op = OP_STOP;
      CT, DT:  m_op = rd_x ? OP_RD : OP_WR;
      default: m_op = OP_WR;
    endcase
    case (st)
      AD:      m_wdata = {addr_r[7:1], 1'b0};
      CM:      m_wdata = cmd_r;
      RA:      m_wdata = {addr_r[7:1], 1'b1};
      CT:      m_wdata = rd_x ? 8'd0 : d0;
      DT:      m_wdata = rd_x ? 8'd0 : mem[xi[IDXW-1:0]];
      default: m_wdata = 8'd0;
    endcase
    case (bus_addr)
      4'h0:    bus_rdata = {3'b000, f_fail, 1'b0, f_dev, f_done, busy};
      4'h2:    bus_rdata = {pec, 1'b0, lastb, proto, 1'b0, ie};
      4'h3:    bus_rdata = cmd_r;
      4'h4:    bus_rdata = addr_r;
      4'h5:    bus_rdata = d0;
      4'h6:    bus_rdata = d1;
      4'h7:    bus_rdata = mem[cidx];
      4'hD:    bus_rdata = {6'b0, aux};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module smbus_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       m_valid,
  input logic [1:0] m_op,
  input logic [7:0] m_wdata,
  input logic       m_last,
  input logic       m_done,
  input logic       m_nack,
  input logic       f_done
);
  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h2 && bus_wdata[6] && bus_wdata[4:2] == 3'd5 && !m_valid) |=> (m_valid && m_op == 2'd0));
  p_ctl_selfclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h2) |-> (!bus_rdata[6] && !bus_rdata[1]));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_done) |=> (m_valid && $stable(m_op) && $stable(m_wdata) && $stable(m_last)));
  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_done && m_nack && m_op == 2'd1) |=> (m_valid && m_op == 2'd3));
  p_done_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_done) |-> $past(m_valid && m_done && m_op == 2'd3));
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_done && m_op == 2'd3) |=> !m_valid);
endmodule

bind smbus_host_regs smbus_host_regs_chk u_chk (.*);

// File: tb/smbus_host_regs_bench.sv
`timescale 1ns/1ps
module smbus_host_regs_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic m_valid, m_last;
  logic [1:0] m_op;
  logic [7:0] m_wdata;
  logic m_done = 1'b0, m_nack = 1'b0;
  logic [7:0] m_rdata = '0;

  smbus_host_regs #(.DEPTH(8)) u_smbus_host_regs (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [10:0] exp_bus[$];
  string       exp_bus_tag[$];
  logic [7:0]  exp_rd[$], act_rd[$];
  string       rd_tag[$];
  logic [7:0]  rd_src[$];
  int wcount = 0, nack_at = -1, mcnt = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] it(logic [1:0] op, logic last, logic [7:0] d);
    return {op, last, d};
  endfunction

  // byte master model and bus scoreboard monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      m_done <= 1'b0; m_nack <= 1'b0; mcnt = 0;
    end else if (m_valid && !m_done) begin
      if (mcnt == 2) begin
        logic [10:0] got;
        got = {m_op, m_last, m_wdata};
        m_done <= 1'b1; mcnt = 0;
        m_nack <= (m_op == 2'd1 && wcount == nack_at);
        if (m_op == 2'd1) wcount++;
        if (m_op == 2'd2) m_rdata <= (rd_src.size() != 0) ? rd_src.pop_front() : 8'h00;
        if (exp_bus.size() == 0) chk(1'b0, "R13 unexpected bus request", int'(got), 0);
        else begin
          logic [10:0] e;
          string t;
          e = exp_bus.pop_front(); t = exp_bus_tag.pop_front();
          chk(got == e, t, int'(got), int'(e));
        end
      end else mcnt++;
    end else begin
      m_done <= 1'b0; m_nack <= 1'b0;
    end
  end

  // register read scoreboard monitor
  always @(posedge clk) begin
    while (act_rd.size() != 0 && exp_rd.size() != 0) begin
      logic [7:0] a, e;
      string t;
      a = act_rd.pop_front(); e = exp_rd.pop_front(); t = rd_tag.pop_front();
      chk(a == e, t, int'(a), int'(e));
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1; exp_rd.push_back(e); rd_tag.push_back(t); act_rd.push_back(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic expb(logic [1:0] op, logic last, logic [7:0] d, string t);
    exp_bus.push_back(it(op, last, d)); exp_bus_tag.push_back(t);
  endtask

  task automatic wait_idle(string t);
    for (int n = 0; n < 2000 && m_valid; n++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(exp_bus.size() == 0 && !m_valid, t, exp_bus.size(), 0);
    wcount = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 8'h00, "R1 status");
    rd(4'h2, 8'h00, "R1 control");
    rd(4'h5, 8'h00, "R1 data0");
    rd(4'hD, 8'h00, "R1 aux");
    chk(!m_valid, "R1 no request", m_valid, 0);
    // R2 register readback
    wr(4'h3, 8'hA5); rd(4'h3, 8'hA5, "R2 command");
    wr(4'h6, 8'h3C); rd(4'h6, 8'h3C, "R2 data1");
    wr(4'h4, 8'h5B); rd(4'h4, 8'h5B, "R2 address");
    wr(4'h5, 8'h81); rd(4'h5, 8'h81, "R2 data0");
    wr(4'hD, 8'hFF); rd(4'hD, 8'h03, "R2 aux keeps bits 1:0");
    wr(4'hD, 8'h02);
    // R3 buffer walk with index reset by control read
    peek(4'h2);
    wr(4'h7, 8'h11); wr(4'h7, 8'h22); wr(4'h7, 8'h33);
    rd(4'h2, 8'h00, "R3 control read");
    rd(4'h7, 8'h11, "R3 port0"); rd(4'h7, 8'h22, "R3 port1"); rd(4'h7, 8'h33, "R3 port2");

    // R5 block write, R7 busy/done, R13 restart ignored
    wr(4'h4, 8'hA0); wr(4'h3, 8'h10); wr(4'h5, 8'h03);
    peek(4'h2);
    wr(4'h7, 8'hB1); wr(4'h7, 8'hB2); wr(4'h7, 8'hB3);
    wr(4'h0, 8'hFF);
    expb(0, 0, 8'h00, "R5 start");
    expb(1, 0, 8'hA0, "R5 address");
    expb(1, 0, 8'h10, "R5 command");
    expb(1, 0, 8'h03, "R5 count");
    expb(1, 0, 8'hB1, "R5 byte0");
    expb(1, 0, 8'hB2, "R5 byte1");
    expb(1, 0, 8'hB3, "R5 byte2");
    expb(3, 0, 8'h00, "R5 stop");
    wr(4'h2, 8'h54);
    rd(4'h0, 8'h01, "R7 busy while running");
    wr(4'h2, 8'h54);
    wait_idle("R13 write sequence complete, no extra");
    rd(4'h0, 8'h02, "R7 complete set, busy clear");
    rd(4'h2, 8'h14, "R4 start reads zero");
    // R8 write-one-to-clear
    wr(4'h0, 8'h01); rd(4'h0, 8'h02, "R8 zero bits keep flag");
    wr(4'h0, 8'h02); rd(4'h0, 8'h00, "R8 one clears flag");

    // R6 block read
    wr(4'h4, 8'hA1); wr(4'h3, 8'h20);
    rd_src.push_back(8'h04);
    rd_src.push_back(8'hC1); rd_src.push_back(8'hC2); rd_src.push_back(8'hC3); rd_src.push_back(8'hC4);
    expb(0, 0, 8'h00, "R6 start");
    expb(1, 0, 8'hA0, "R6 address write dir");
    expb(1, 0, 8'h20, "R6 command");
    expb(0, 0, 8'h00, "R6 repeated start");
    expb(1, 0, 8'hA1, "R6 address read dir");
    expb(2, 0, 8'h00, "R6 count read");
    expb(2, 0, 8'h00, "R6 data0");
    expb(2, 0, 8'h00, "R6 data1");
    expb(2, 0, 8'h00, "R6 data2");
    expb(2, 1, 8'h00, "R6 data3 last");
    expb(3, 0, 8'h00, "R6 stop");
    wr(4'h2, 8'h54);
    wait_idle("R6 read sequence complete");
    rd(4'h0, 8'h02, "R7 read complete");
    rd(4'h5, 8'h04, "R6 count in data0");
    peek(4'h2);
    rd(4'h7, 8'hC1, "R6 rx0"); rd(4'h7, 8'hC2, "R6 rx1");
    rd(4'h7, 8'hC3, "R6 rx2"); rd(4'h7, 8'hC4, "R6 rx3");
    wr(4'h0, 8'hFF);

    // R10 count over DEPTH and count zero
    rd_src.push_back(8'h09);
    expb(0, 0, 8'h00, "R10 start"); expb(1, 0, 8'hA0, "R10 address");
    expb(1, 0, 8'h20, "R10 command"); expb(0, 0, 8'h00, "R10 restart");
    expb(1, 0, 8'hA1, "R10 address rd"); expb(2, 0, 8'h00, "R10 count");
    expb(3, 0, 8'h00, "R10 stop after big count");
    wr(4'h2, 8'h54);
    wait_idle("R10 big count sequence");
    rd(4'h0, 8'h04, "R10 device error on count 9");
    rd(4'h5, 8'h09, "R10 data0 holds count");
    wr(4'h0, 8'hFF);
    rd_src.push_back(8'h00);
    expb(0, 0, 8'h00, "R10 start"); expb(1, 0, 8'hA0, "R10 address");
    expb(1, 0, 8'h20, "R10 command"); expb(0, 0, 8'h00, "R10 restart");
    expb(1, 0, 8'hA1, "R10 address rd"); expb(2, 0, 8'h00, "R10 count");
    expb(3, 0, 8'h00, "R10 stop after zero count");
    wr(4'h2, 8'h54);
    wait_idle("R10 zero count sequence");
    rd(4'h0, 8'h04, "R10 device error on count 0");
    wr(4'h0, 8'hFF);

    // R9 not-acknowledge on command byte
    wr(4'h4, 8'hA0); wr(4'h5, 8'h02);
    nack_at = 1;
    expb(0, 0, 8'h00, "R9 start"); expb(1, 0, 8'hA0, "R9 address");
    expb(1, 0, 8'h20, "R9 command nacked"); expb(3, 0, 8'h00, "R9 stop");
    wr(4'h2, 8'h54);
    wait_idle("R9 nack sequence");
    nack_at = -1;
    rd(4'h0, 8'h04, "R9 device error, no complete");
    wr(4'h0, 8'hFF);

    // R11 kill during first request
    expb(0, 0, 8'h00, "R11 start"); expb(3, 0, 8'h00, "R11 stop");
    wr(4'h2, 8'h54);
    wr(4'h2, 8'h02);
    wait_idle("R11 kill sequence");
    rd(4'h0, 8'h10, "R11 failed set");
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h00, "R8 failed cleared");

    // R12 frozen index with aux bit 1 clear
    peek(4'h2);
    wr(4'hD, 8'h00);
    wr(4'h7, 8'h77); wr(4'h7, 8'h88);
    rd(4'h7, 8'h88, "R12 same entry"); rd(4'h7, 8'h88, "R12 index frozen");
    wr(4'hD, 8'h02);
    peek(4'h2);
    rd(4'h7, 8'h88, "R12 entry0"); rd(4'h7, 8'hC2, "R12 entry1 untouched");

    // R4 start with a non-block protocol value
    wr(4'h2, 8'h40);
    wait_idle("R4 no launch with protocol 0");
    rd(4'h0, 8'h00, "R4 not busy");
    rd(4'h2, 8'h00, "R4 control readback");

    repeat (4) @(negedge clk);
    chk(exp_rd.size() == 0, "R1 read queue drained", exp_rd.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule